// File: doc/BRIEF.md
# Scatter-Gather Descriptor Table Walker

This block is the sequencing core of a bus-master DMA channel. Given the base address of a descriptor table in system memory, a byte count for the local sector buffer and a transfer direction, it fetches 8-byte region descriptors one by one through a valid/ready memory request port. It then issues data bursts that move the buffer contents to memory or fill the buffer from memory, each burst bounded by whatever remains in the buffer and in the current region.

The walk ends normally once the buffer byte count is used up. It ends with a short-table error when the table runs out first: either the descriptor just consumed carried the final flag, or the descriptor pointer has already advanced a full 4096-byte page beyond the table base. Data movement itself happens outside the block. The burst request carries the system address, the byte count, the direction and the current buffer index, and the host side uses these to perform the copy. Descriptor words return on a separate read-data path.

Top module: `sg_table_walker`

## Requirements
- R1: During and after reset, `active`, `req_valid`, `done` and `table_short` are all low.
- R2: The walk is started by `start` while idle. Descriptor fetches are requests with `req_desc`=1, `req_write`=0 and `req_len`=8. The first fetch uses `table_base`, and each accepted fetch advances the pointer by 8.
- R3: In a returned descriptor, `rd_data[31:0]` is the region address, and `rd_data[63:32]` is the control word. The region byte count is control bits [15:0] with bit 0 cleared.
- R4: A decoded region byte count of zero gives a region of 65536 bytes.
- R5: Control bit 31 (`rd_data[63]`) marks the final descriptor.
- R6: Each data burst has length min(buffer bytes left, region bytes left). Its address starts at the region address, and its `req_buf_idx` starts at 0. Region address and buffer index both advance by the burst length after each accepted burst.
- R7: `req_write` on data bursts equals `to_mem` as sampled at `start` (1 = buffer to memory, 0 = memory to buffer).
- R8: When a region is used up after a final descriptor while buffer bytes remain, the walk ends with a one-cycle `table_short` pulse, and `done` stays low.
- R9: No descriptor is fetched once the pointer is 4096 or more bytes past `table_base`. Reaching this point with buffer bytes left ends the walk with `table_short`.
- R10: When the buffer count reaches zero, the walk ends with a one-cycle `done` pulse and issues no further fetch. A start with a zero byte count gives `done` with no request at all.
- R11: `active` is high from the cycle after an accepted start until the cycle in which `done` or `table_short` pulses. In that cycle `active` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (ignored while active) |
| table_base | input | 32 | Descriptor table base address |
| xfer_bytes | input | BUF_W | Bytes to move through the local buffer |
| to_mem | input | 1 | 1: buffer to memory, 0: memory to buffer |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_desc | output | 1 | Request is a descriptor fetch |
| req_write | output | 1 | Request writes memory |
| req_addr | output | 32 | Request system address |
| req_len | output | 17 | Request byte count |
| req_buf_idx | output | BUF_W | Local buffer index of a data burst |
| rd_valid | input | 1 | Descriptor word valid |
| rd_data | input | 64 | Descriptor word, little-endian |
| active | output | 1 | Walk in progress |
| done | output | 1 | Normal completion pulse |
| table_short | output | 1 | Table exhausted before buffer drained pulse |

## Verification
The assertions assume three things about the inputs. `rd_valid` is raised only once per accepted descriptor fetch and only while the reply is awaited. `start` is pulsed only while the walker is idle. The memory side never withdraws `req_ready` in a way that breaks the handshake. The bench memory model returns each descriptor a random 1 to 3 cycles after acceptance, asserts ready randomly only against a pending request, and starts a new walk only after the previous one has reported `done` or `table_short`. Random tables mix random region lengths, final flags and byte counts, some larger than the table covers. Directed cases add the zero-length region, the cleared bit 0, the full-page cut-off and a zero byte count.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned LEN_W      = 17;
  localparam int unsigned DESC_BYTES = 8;
  localparam int unsigned WORD_W     = 64;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_FWAIT,
    ST_BURST
  } walk_state_e;
endpackage

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode
  import sgw_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output logic [ADDR_W-1:0] region_addr,
  output logic [LEN_W-1:0]  region_len,
  output logic              is_final
);
  logic [15:0] even_count;
  logic        unused_ctrl_bits;

  assign even_count       = {word[47:33], 1'b0};
  assign region_addr      = word[31:0];
  assign is_final         = word[63];
  assign unused_ctrl_bits = ^{word[62:48], word[32]};

  always_comb begin
    if (even_count == 16'd0) region_len = LEN_W'(17'h10000);
    else                     region_len = LEN_W'(even_count);
  end
endmodule

// File: rtl/sgw_burst_sizer.sv
module sgw_burst_sizer
  import sgw_pkg::*;
#(
  parameter int unsigned BUF_W = 20
) (
  input  logic [BUF_W-1:0] buf_left,
  input  logic [LEN_W-1:0] region_left,
  output logic [LEN_W-1:0] burst_len
);
  always_comb begin
    if (buf_left < BUF_W'(region_left)) burst_len = LEN_W'(buf_left);
    else                                burst_len = region_left;
  end
endmodule

// File: rtl/sgw_table_guard.sv
module sgw_table_guard
  import sgw_pkg::*;
#(
  parameter int unsigned TABLE_LIMIT = 4096
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] ptr_addr,
  input  logic              final_seen,
  output logic              table_end
);
  logic [ADDR_W-1:0] walked;

  assign walked    = ptr_addr - base_addr;
  assign table_end = final_seen || (walked >= ADDR_W'(TABLE_LIMIT));
endmodule

// File: rtl/sg_table_walker.sv
module sg_table_walker
  import sgw_pkg::*;
#(
  parameter int unsigned BUF_W       = 20,
  parameter int unsigned TABLE_LIMIT = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       table_base,
  input  logic [BUF_W-1:0]  xfer_bytes,
  input  logic              to_mem,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_desc,
  output logic              req_write,
  output logic [31:0]       req_addr,
  output logic [16:0]       req_len,
  output logic [BUF_W-1:0]  req_buf_idx,
  input  logic              rd_valid,
  input  logic [63:0]       rd_data,
  output logic              active,
  output logic              done,
  output logic              table_short
);
  walk_state_e       state_q, state_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic              final_q, final_d;
  logic [BUF_W-1:0]  left_q, left_d;
  logic [BUF_W-1:0]  idx_q, idx_d;
  logic              dir_q, dir_d;
  logic              done_q, done_d;
  logic              short_q, short_d;

  logic [ADDR_W-1:0] dec_addr;
  logic [LEN_W-1:0]  dec_len;
  logic              dec_final;
  logic [LEN_W-1:0]  burst_len;
  logic              table_end;
  logic              accept;

  sgw_desc_decode u_decode (
    .word        (rd_data),
    .region_addr (dec_addr),
    .region_len  (dec_len),
    .is_final    (dec_final)
  );

  sgw_burst_sizer #(.BUF_W(BUF_W)) u_sizer (
    .buf_left    (left_q),
    .region_left (rem_q),
    .burst_len   (burst_len)
  );

  sgw_table_guard #(.TABLE_LIMIT(TABLE_LIMIT)) u_guard (
    .base_addr  (base_q),
    .ptr_addr   (ptr_q),
    .final_seen (final_q),
    .table_end  (table_end)
  );

  assign accept = req_valid && req_ready;

  // next-state logic
  always_comb begin
    state_d = state_q;
    base_d  = base_q;
    ptr_d   = ptr_q;
    raddr_d = raddr_q;
    rem_d   = rem_q;
    final_d = final_q;
    left_d  = left_q;
    idx_d   = idx_q;
    dir_d   = dir_q;
    done_d  = 1'b0;
    short_d = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          base_d  = table_base;
          ptr_d   = table_base;
          left_d  = xfer_bytes;
          idx_d   = '0;
          rem_d   = '0;
          final_d = 1'b0;
          dir_d   = to_mem;
          state_d = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (left_q == '0) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (rem_q == '0) begin
          if (table_end) begin
            short_d = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_FETCH;
          end
        end else begin
          state_d = ST_BURST;
        end
      end
      ST_FETCH: begin
        if (accept) begin
          ptr_d   = ptr_q + ADDR_W'(DESC_BYTES);
          state_d = ST_FWAIT;
        end
      end
      ST_FWAIT: begin
        if (rd_valid) begin
          raddr_d = dec_addr;
          rem_d   = dec_len;
          final_d = dec_final;
          state_d = ST_CHECK;
        end
      end
      ST_BURST: begin
        if (accept) begin
          raddr_d = raddr_q + ADDR_W'(burst_len);
          rem_d   = rem_q - burst_len;
          left_d  = left_q - BUF_W'(burst_len);
          idx_d   = idx_q + BUF_W'(burst_len);
          state_d = ST_CHECK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      base_q  <= '0;
      ptr_q   <= '0;
      raddr_q <= '0;
      rem_q   <= '0;
      final_q <= 1'b0;
      left_q  <= '0;
      idx_q   <= '0;
      dir_q   <= 1'b0;
      done_q  <= 1'b0;
      short_q <= 1'b0;
    end else begin
      state_q <= state_d;
      base_q  <= base_d;
      ptr_q   <= ptr_d;
      raddr_q <= raddr_d;
      rem_q   <= rem_d;
      final_q <= final_d;
      left_q  <= left_d;
      idx_q   <= idx_d;
      dir_q   <= dir_d;
      done_q  <= done_d;
      short_q <= short_d;
    end
  end

  // outputs
  assign req_valid   = (state_q == ST_FETCH) || (state_q == ST_BURST);
  assign req_desc    = (state_q == ST_FETCH);
  assign req_write   = (state_q == ST_BURST) && dir_q;
  assign req_addr    = (state_q == ST_FETCH) ? ptr_q : raddr_q;
  assign req_len     = (state_q == ST_FETCH) ? LEN_W'(DESC_BYTES) : burst_len;
  assign req_buf_idx = idx_q;
  assign active      = (state_q != ST_IDLE);
  assign done        = done_q;
  assign table_short = short_q;
endmodule

// File: rtl/sgw_walk_checker.sv
module sgw_walk_checker #(
  parameter int unsigned BUF_W       = 20,
  parameter int unsigned TABLE_LIMIT = 4096
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_desc,
  input logic             req_write,
  input logic [31:0]      req_addr,
  input logic [16:0]      req_len,
  input logic [BUF_W-1:0] req_buf_idx,
  input logic             active,
  input logic             done,
  input logic             table_short
);
  localparam int unsigned MAX_FETCH = TABLE_LIMIT / 8;
  logic [31:0] fetch_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_cnt <= '0;
    end else if (start && !active) begin
      fetch_cnt <= '0;
    end else if (req_valid && req_ready && req_desc) begin
      fetch_cnt <= fetch_cnt + 32'd1;
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !active && !req_valid);

  p_fetch_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_desc) |-> (req_len == 17'd8) && !req_write);

  p_hold_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid && $stable(req_addr) && $stable(req_len)
      && $stable(req_desc) && $stable(req_buf_idx));

  p_burst_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_desc) |-> (req_len != 17'd0) && (req_len <= 17'h10000));

  p_fetch_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_cnt <= 32'(MAX_FETCH));

  p_end_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && table_short));

  p_end_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || table_short) |-> !active && !req_valid);

  p_start_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !active) |=> active);
endmodule

bind sg_table_walker sgw_walk_checker #(.BUF_W(BUF_W), .TABLE_LIMIT(TABLE_LIMIT)) u_walk_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_desc    (req_desc),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .req_len     (req_len),
  .req_buf_idx (req_buf_idx),
  .active      (active),
  .done        (done),
  .table_short (table_short)
);

// File: tb/sg_table_walker_bench.sv
module sg_table_walker_bench;
  localparam int BUF_W = 20;
  localparam int NDESC = 600;
  localparam int NLOG  = 1024;

  logic             clk;
  logic             rst_n;
  logic             start;
  logic [31:0]      table_base;
  logic [BUF_W-1:0] xfer_bytes;
  logic             to_mem;
  logic             req_valid, req_ready, req_desc, req_write;
  logic [31:0]      req_addr;
  logic [16:0]      req_len;
  logic [BUF_W-1:0] req_buf_idx;
  logic             rd_valid;
  logic [63:0]      rd_data;
  logic             active, done, table_short;

  sg_table_walker #(.BUF_W(BUF_W), .TABLE_LIMIT(4096)) u_sg_table_walker (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [63:0] desc_mem [NDESC];
  logic [31:0] cur_base;

  // observation logs
  int          n_fetch_obs, n_burst_obs, obs_done, obs_short;
  logic [31:0] fetch_addr_obs [NLOG];
  logic [31:0] b_addr_obs [NLOG];
  logic [16:0] b_len_obs [NLOG];
  logic [BUF_W-1:0] b_idx_obs [NLOG];
  logic        b_wr_obs [NLOG];

  // expected logs
  int          n_fetch_exp, n_burst_exp, exp_short;
  logic [31:0] b_addr_exp [NLOG];
  logic [16:0] b_len_exp [NLOG];
  logic [BUF_W-1:0] b_idx_exp [NLOG];

  int pend;
  logic [63:0] pend_data;

  task automatic chk(input string tag, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000) begin
      errors++;
      $display("FAIL R11 watchdog expired actual=%0d expected=<190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // memory model and monitor, all at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      req_ready = 1'b0;
      rd_valid  = 1'b0;
      rd_data   = '0;
      pend      = 0;
    end else begin
      rd_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          rd_valid = 1'b1;
          rd_data  = pend_data;
        end
      end
      if (done) obs_done++;
      if (table_short) obs_short++;
      req_ready = req_valid && ($urandom % 4 != 0);
      if (req_valid && req_ready) begin
        if (req_desc) begin
          int k;
          k = int'((req_addr - cur_base) >> 3);
          if (n_fetch_obs < NLOG) fetch_addr_obs[n_fetch_obs] = req_addr;
          n_fetch_obs++;
          pend_data = (k >= 0 && k < NDESC) ? desc_mem[k] : 64'd0;
          pend = 1 + int'($urandom % 3);
        end else begin
          if (n_burst_obs < NLOG) begin
            b_addr_obs[n_burst_obs] = req_addr;
            b_len_obs[n_burst_obs]  = req_len;
            b_idx_obs[n_burst_obs]  = req_buf_idx;
            b_wr_obs[n_burst_obs]   = req_write;
          end
          n_burst_obs++;
        end
      end
    end
  end

  // expected walk, from the requirements
  task automatic model_walk(input logic [31:0] base, input int nbytes);
    longint ptr, left, idx, rem, raddr, b, len;
    bit last;
    ptr = base; left = nbytes; idx = 0; rem = 0; raddr = 0; last = 0;
    n_fetch_exp = 0; n_burst_exp = 0; exp_short = 0;
    while (1) begin
      if (left == 0) break;
      if (rem == 0) begin
        if (last || (ptr - base) >= 4096) begin
          exp_short = 1;
          break;
        end
        raddr = desc_mem[(ptr - base) / 8][31:0];
        len   = desc_mem[(ptr - base) / 8][47:32] & 16'hfffe;
        if (len == 0) len = 65536;
        rem   = len;
        last  = desc_mem[(ptr - base) / 8][63];
        ptr   = ptr + 8;
        n_fetch_exp++;
      end
      b = (left < rem) ? left : rem;
      if (n_burst_exp < NLOG) begin
        b_addr_exp[n_burst_exp] = 32'(raddr);
        b_len_exp[n_burst_exp]  = 17'(b);
        b_idx_exp[n_burst_exp]  = BUF_W'(idx);
      end
      n_burst_exp++;
      raddr = (raddr + b) & 64'hffff_ffff;
      rem -= b; left -= b; idx += b;
    end
  endtask

  task automatic run_walk(input string name, input logic [31:0] base, input int nbytes,
                          input bit dir);
    int t;
    model_walk(base, nbytes);
    n_fetch_obs = 0; n_burst_obs = 0; obs_done = 0; obs_short = 0;
    cur_base = base;
    @(negedge clk);
    start = 1'b1; table_base = base; xfer_bytes = BUF_W'(nbytes); to_mem = dir;
    @(negedge clk);
    start = 1'b0;
    chk({name, " R11 active after start"}, active == 1'b1, active, 1);
    t = 0;
    while (obs_done + obs_short == 0 && t < 150000) begin
      @(negedge clk);
      t++;
    end
    chk({name, " R11 idle at end"}, active == 1'b0, active, 0);
    if (exp_short)
      chk({name, " R8 R9 short table outcome"}, obs_short == 1 && obs_done == 0,
          obs_short, 1);
    else
      chk({name, " R10 done outcome"}, obs_done == 1 && obs_short == 0, obs_done, 1);
    chk({name, " R2 R9 R10 fetch count"}, n_fetch_obs == n_fetch_exp, n_fetch_obs,
        n_fetch_exp);
    for (int i = 0; i < n_fetch_obs && i < NLOG; i++)
      if (fetch_addr_obs[i] != base + 32'(8 * i))
        chk({name, " R2 fetch address"}, 0, fetch_addr_obs[i], base + 32'(8 * i));
    chk({name, " R6 burst count"}, n_burst_obs == n_burst_exp, n_burst_obs, n_burst_exp);
    if (n_burst_obs == n_burst_exp) begin
      for (int i = 0; i < n_burst_obs && i < NLOG; i++) begin
        if (b_addr_obs[i] != b_addr_exp[i])
          chk({name, " R3 R6 burst address"}, 0, b_addr_obs[i], b_addr_exp[i]);
        if (b_len_obs[i] != b_len_exp[i])
          chk({name, " R3 R4 R6 burst length"}, 0, b_len_obs[i], b_len_exp[i]);
        if (b_idx_obs[i] != b_idx_exp[i])
          chk({name, " R6 buffer index"}, 0, b_idx_obs[i], b_idx_exp[i]);
        if (b_wr_obs[i] != dir)
          chk({name, " R7 direction"}, 0, b_wr_obs[i], dir);
      end
      chk({name, " R3 R6 R7 burst contents"}, 1, 0, 0);
    end
  endtask

  task automatic clear_table();
    for (int i = 0; i < NDESC; i++) desc_mem[i] = 64'd0;
  endtask

  initial begin
    void'($urandom(32'd1357));
    start = 1'b0; table_base = '0; xfer_bytes = '0; to_mem = 1'b0;
    cur_base = '0;
    n_fetch_obs = 0; n_burst_obs = 0; obs_done = 0; obs_short = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", !active && !req_valid && !done && !table_short,
        {active, req_valid, done, table_short}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", !active && !req_valid, {active, req_valid}, 0);

    // zero byte count
    clear_table();
    run_walk("zero-count R10", 32'h0000_1000, 0, 1'b1);

    // two descriptors, exact drain, write direction
    clear_table();
    desc_mem[0] = {32'h0000_0100, 32'h2000_0000};
    desc_mem[1] = {32'h8000_0040, 32'h3000_0010};
    run_walk("two-region R2 R5", 32'h0000_2000, 320, 1'b1);

    // bit 0 of the count is dropped
    clear_table();
    desc_mem[0] = {32'h8000_0007, 32'h4000_0000};
    run_walk("odd-count R3", 32'h0000_3000, 6, 1'b1);

    // zero count means 65536, then final flag stops with buffer left
    clear_table();
    desc_mem[0] = {32'h8000_0000, 32'h5000_0000};
    run_walk("64k-region R4 R8", 32'h0000_4000, 70000, 1'b0);

    // buffer smaller than region
    clear_table();
    desc_mem[0] = {32'h0000_0064, 32'h6000_0000};
    run_walk("partial-region R10", 32'h0000_5000, 10, 1'b0);

    // page limit: 512 descriptors without final flag
    clear_table();
    for (int i = 0; i < 520; i++) desc_mem[i] = {32'h0000_0002, 32'h7000_0000 + 32'(16 * i)};
    run_walk("page-limit R9", 32'h0001_0000, 5000, 1'b1);

    // random tables
    for (int r = 0; r < 30; r++) begin
      int k;
      logic [31:0] ctrl;
      clear_table();
      k = 1 + int'($urandom % 8);
      for (int i = 0; i < k; i++) begin
        ctrl = 32'($urandom % 700);
        if ($urandom % 10 == 0) ctrl = 32'd0;
        if (i == k - 1 && ($urandom % 3 != 0)) ctrl[31] = 1'b1;
        desc_mem[i] = {ctrl, $urandom};
      end
      run_walk("random R6 R7", {$urandom, 3'b000} & 32'h00ff_fff8,
               int'($urandom % 3000), 1'($urandom % 2));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule